// File: doc/BRIEF.md
# Key-Guarded Interrupt Configuration Register

This block is one 32-bit write port that decodes a guard value in the top half of each write. Each group of command bits in the bottom half only takes effect when that guard value matches the key assigned to its group. Two configuration bits are kept as state and can be read back. For both of them, 0 means the feature is enabled. The other command bits are never stored for reading:

- one pair of bits sets and clears an NMI-pending flag;
- one pair of bits sets and clears an exception-pending flag;
- one bit asks for a system reset, and it needs its own key;
- one bit resets the interrupt controller, and it needs no key.

Software uses the block by writing a single word that holds both the key and the command bits. The pending flags and the two configuration bits drive the interrupt logic next to the block. The two reset outputs are single-cycle pulses, and they go to whatever logic performs the resets.

Top module: `keyed_ctrl_reg`

## Requirements
- R1: After reset, `rd_data` is 0, both configuration outputs are 0 (enabled), both pending flags are 0 and both reset pulses are 0.
- R2: A write whose bits 31:16 equal KEY_CFG (default 0xFA05) loads bit 0 into the hardware-stack-off output and bit 1 into the nesting-off output. These values appear on the cycle after the write. `rd_data` returns them in bits 1:0 and reads 0 in bits 31:2. Bits 15:8 of any write are ignored.
- R3: A write with any other key leaves both configuration bits unchanged.
- R4: With key KEY_PEND (default 0xBCAF), bit 2 sets the NMI-pending flag and bit 3 clears it. The flag changes on the cycle after the write and holds until the next such command.
- R5: With key KEY_PEND, bit 4 sets the exception-pending flag and bit 5 clears it. The timing is the same as for the NMI flag.
- R6: Bits 2 to 5 have no effect on either pending flag when the key is not KEY_PEND.
- R7: When the set bit and the clear bit of the same flag are both 1 in one keyed write, the flag ends at 0. The other flag is not affected.
- R8: Bit 7 with key KEY_SYS (default 0xBEEF) drives `sys_rst_pulse` high for exactly the one cycle after the write. With any other key, bit 7 produces no pulse.
- R9: Bit 6 drives `ctrl_rst_pulse` high for exactly the one cycle after the write, whatever the value of bits 31:16.
- R10: While `wr_en` is low, no output changes and no pulse is produced, whatever is on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 32 | Write word: key in 31:16, command bits in 7:0 |
| rd_data | output | 32 | Readback: configuration bits in 1:0, zero above |
| hwstk_off | output | 1 | Hardware stack control bit (0 = enabled) |
| nest_off | output | 1 | Nesting control bit (0 = enabled) |
| nmi_pend | output | 1 | NMI-pending flag |
| exc_pend | output | 1 | Exception-pending flag |
| ctrl_rst_pulse | output | 1 | One-cycle controller reset request |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default keys 0xFA05, 0xBCAF and 0xBEEF. With these values it can aim each command bit at its own key and also at the other two keys, and it can use keys that differ from a real key by one bit. This exercises the match-or-ignore rule for every group. The same key values also let it check the clear-wins case and the pulse width on the cycles just before and just after each write.

// File: rtl/kcr_pkg.sv
package kcr_pkg;

    localparam int REG_W      = 32;
    localparam int KEY_W      = 16;
    localparam int KEY_LSB    = REG_W - KEY_W;
    localparam int CFG_W      = 2;
    localparam int NUM_FLAGS  = 2;
    localparam int NUM_PULSES = 2;

    // Command bit positions inside the low half of a write
    localparam int BIT_CFG_LSB = 0;
    localparam int BIT_NMI_SET = 2;
    localparam int BIT_NMI_CLR = 3;
    localparam int BIT_EXC_SET = 4;
    localparam int BIT_EXC_CLR = 5;
    localparam int BIT_CTL_RST = 6;
    localparam int BIT_SYS_RST = 7;

    // Flag and pulse lane indices
    localparam int FLG_NMI = 0;
    localparam int FLG_EXC = 1;
    localparam int PLS_CTL = 0;
    localparam int PLS_SYS = 1;

    typedef struct packed {
        logic                  cfg_wr;
        logic [CFG_W-1:0]      cfg_val;
        logic [NUM_FLAGS-1:0]  flag_set;
        logic [NUM_FLAGS-1:0]  flag_clr;
        logic [NUM_PULSES-1:0] pulse_req;
    } kcr_cmd_t;

endpackage

// File: rtl/kcr_decode.sv
module kcr_decode
    import kcr_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY_CFG  = 16'hFA05,
    parameter logic [KEY_W-1:0] KEY_PEND = 16'hBCAF,
    parameter logic [KEY_W-1:0] KEY_SYS  = 16'hBEEF
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output kcr_cmd_t         cmd_o
);

    logic [KEY_W-1:0] key;
    logic             hit_cfg;
    logic             hit_pend;
    logic             hit_sys;

    assign key      = wr_data[REG_W-1:KEY_LSB];
    assign hit_cfg  = wr_en && (key == KEY_CFG);
    assign hit_pend = wr_en && (key == KEY_PEND);
    assign hit_sys  = wr_en && (key == KEY_SYS);

    always_comb begin
        cmd_o = '0;
        if (hit_cfg) begin
            cmd_o.cfg_wr  = 1'b1;
            cmd_o.cfg_val = wr_data[BIT_CFG_LSB +: CFG_W];
        end
        if (hit_pend) begin
            cmd_o.flag_set[FLG_NMI] = wr_data[BIT_NMI_SET];
            cmd_o.flag_clr[FLG_NMI] = wr_data[BIT_NMI_CLR];
            cmd_o.flag_set[FLG_EXC] = wr_data[BIT_EXC_SET];
            cmd_o.flag_clr[FLG_EXC] = wr_data[BIT_EXC_CLR];
        end
        cmd_o.pulse_req[PLS_SYS] = hit_sys && wr_data[BIT_SYS_RST];
        cmd_o.pulse_req[PLS_CTL] = wr_en && wr_data[BIT_CTL_RST];
    end

endmodule

// File: rtl/kcr_flag.sv
module kcr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.flag = 1'b0;
        end else if (set_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R4 and R5: a lone set raises the flag on the next cycle
    assert_set_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> flag_o);

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);

    // R6: flag moves only when a command arrived
    assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));

endmodule

// File: rtl/kcr_pulse.sv
module kcr_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);

    typedef struct packed {
        logic pulse;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    // R8: a pulse always traces back to a request one cycle earlier
    assert_pulse_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(req_i));

    // R9: the pulse drops right after the request goes away
    assert_pulse_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !pulse_o);

endmodule

// File: rtl/keyed_ctrl_reg.sv
module keyed_ctrl_reg
    import kcr_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY_CFG  = 16'hFA05,
    parameter logic [KEY_W-1:0] KEY_PEND = 16'hBCAF,
    parameter logic [KEY_W-1:0] KEY_SYS  = 16'hBEEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             hwstk_off,
    output logic             nest_off,
    output logic             nmi_pend,
    output logic             exc_pend,
    output logic             ctrl_rst_pulse,
    output logic             sys_rst_pulse
);

    kcr_cmd_t cmd;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    logic [NUM_FLAGS-1:0]  flags;
    logic [NUM_PULSES-1:0] pulses;

    kcr_decode #(
        .KEY_CFG  (KEY_CFG),
        .KEY_PEND (KEY_PEND),
        .KEY_SYS  (KEY_SYS)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd_o   (cmd)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (cmd.cfg_wr) begin
            cfg_d.cfg = cmd.cfg_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        kcr_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (cmd.flag_set[gi]),
            .clr_i  (cmd.flag_clr[gi]),
            .flag_o (flags[gi])
        );
    end

    for (genvar gp = 0; gp < NUM_PULSES; gp++) begin : g_pulse
        kcr_pulse u_pulse (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (cmd.pulse_req[gp]),
            .pulse_o (pulses[gp])
        );
    end

    assign rd_data        = {{(REG_W-CFG_W){1'b0}}, cfg_q.cfg};
    assign hwstk_off      = cfg_q.cfg[0];
    assign nest_off       = cfg_q.cfg[1];
    assign nmi_pend       = flags[FLG_NMI];
    assign exc_pend       = flags[FLG_EXC];
    assign ctrl_rst_pulse = pulses[PLS_CTL];
    assign sys_rst_pulse  = pulses[PLS_SYS];

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.cfg_wr |=> (rd_data[CFG_W-1:0] == $past(wr_data[CFG_W-1:0])));

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd.cfg_wr |=> $stable(rd_data));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable({hwstk_off, nest_off, nmi_pend, exc_pend})
                    && !ctrl_rst_pulse && !sys_rst_pulse));

    assert_sys_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_pulse |-> $past(wr_data[REG_W-1:KEY_LSB] == KEY_SYS));

endmodule

// File: tb/tb_keyed_ctrl_reg.sv
module tb_keyed_ctrl_reg;

    localparam time HALF = 10ns; // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        hwstk_off, nest_off, nmi_pend, exc_pend;
    logic        ctrl_rst_pulse, sys_rst_pulse;

    keyed_ctrl_reg dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .hwstk_off      (hwstk_off),
        .nest_off       (nest_off),
        .nmi_pend       (nmi_pend),
        .exc_pend       (exc_pend),
        .ctrl_rst_pulse (ctrl_rst_pulse),
        .sys_rst_pulse  (sys_rst_pulse)
    );

    always #HALF clk = ~clk;

    typedef struct {
        logic [37:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    logic [1:0] m_cfg = 2'b00;
    logic       m_nmi = 1'b0;
    logic       m_exc = 1'b0;

    function automatic logic [37:0] observed();
        return {rd_data, hwstk_off, nest_off, nmi_pend, exc_pend,
                ctrl_rst_pulse, sys_rst_pulse};
    endfunction

    task automatic check(input logic [37:0] exp_v, input string tag);
        logic [37:0] act;
        act = observed();
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    // Driver: one write slot per call, model computes the next state
    task automatic step(input logic en, input logic [31:0] d, input string tag);
        logic [15:0] key;
        logic        crst, srst;
        exp_t        e;
        @(negedge clk);
        wr_en   = en;
        wr_data = d;
        @(posedge clk);
        key  = d[31:16];
        crst = en && d[6];
        srst = en && (key == 16'hBEEF) && d[7];
        if (en && key == 16'hFA05) m_cfg = d[1:0];
        if (en && key == 16'hBCAF) begin
            if (d[3]) m_nmi = 1'b0; else if (d[2]) m_nmi = 1'b1;
            if (d[5]) m_exc = 1'b0; else if (d[4]) m_exc = 1'b1;
        end
        e.val = {30'b0, m_cfg, m_cfg[0], m_cfg[1], m_nmi, m_exc, crst, srst};
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares each expected item half a cycle after its edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.val, e.tag);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(38'h0, "R1 reset");
        rst_n = 1'b1;
        step(0, 32'h0, "R1 idle");

        step(1, 32'hFA05_0003, "R2 load 11");
        step(1, 32'hFA05_0001, "R2 load 01");
        step(1, 32'hFA05_FF02, "R2 reserved bits ignored");
        step(1, 32'hFA04_0001, "R3 near key");
        step(1, 32'hBCAF_0001, "R3 pend key");
        step(1, 32'hBEEF_0003, "R3 sys key");

        step(1, 32'hBCAF_0004, "R4 nmi set");
        step(0, 32'h0, "R4 nmi holds");
        step(1, 32'hBCAF_0008, "R4 nmi clear");
        step(1, 32'hBCAF_0010, "R5 exc set");
        step(1, 32'hBCAF_0020, "R5 exc clear");

        step(1, 32'hFA05_0016, "R6 cfg key on flag bits");
        step(1, 32'hBCAE_0014, "R6 near key");
        step(1, 32'hBEEF_0014, "R6 sys key");

        step(1, 32'hBCAF_0014, "R7 both set");
        step(1, 32'hBCAF_000C, "R7 nmi set+clr");
        step(1, 32'hBCAF_0030, "R7 exc set+clr");

        step(1, 32'hBEEF_0080, "R8 sys pulse");
        step(0, 32'hBEEF_0080, "R8 pulse ends");
        step(1, 32'hBEEE_0080, "R8 wrong key");
        step(1, 32'hFA05_0080, "R8 cfg key");

        step(1, 32'h0000_0040, "R9 no key");
        step(1, 32'h1234_0040, "R9 arbitrary key");
        step(0, 32'h0, "R9 pulse ends");

        step(1, 32'hFA05_0003, "R10 prep");
        step(0, 32'hFA05_0000, "R10 cfg idle");
        step(0, 32'hBCAF_0014, "R10 flags idle");
        step(0, 32'hBEEF_00C0, "R10 pulses idle");
        step(0, 32'h0, "R10 tail");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule